// File: doc/BRIEF.md
# Table-Driven Two-Street Traffic Light Sequencer

This block drives the lamps of a crossing of two streets, each with a red, a yellow and a green lamp. The controller works through a constant table. Each table row pairs an 8-bit lamp word with an 8-bit hold count, and the hold count is measured in coarse ticks. A prescaler divides the system clock into those ticks. When the hold of a row runs out, an index moves to the next row. After the last row the index returns to row zero.

The lamp word is active low: a lamp is lit only while its bit is 0. Bit 6 is street-1 red, bit 5 street-1 yellow, bit 4 street-1 green, bit 3 street-2 red, bit 2 street-2 yellow and bit 1 street-2 green. Bits 7 and 0 are spare and stay at 1. A parameter selects between two tables. The plain table has four rows. The table with safety phases has six rows and adds an all-red row after each yellow row. The stepping logic is the same for both tables, and only the table contents differ.

Top module: `traffic_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the lamp output takes row 0's word, 0xBD (street-1 red, street-2 green). The index goes to 0, the hold count is loaded from row 0 and the prescaler is cleared.
- R2: Lamp bits are active low with the mapping bit6=R1, bit5=Y1, bit4=G1, bit3=R2, bit2=Y2, bit1=G2. Bits 7 and 0 always read 1.
- R3: With `WITH_SAFETY`=0 the output cycles through 0xBD, 0xBB, 0xE7, 0xD7 and then repeats.
- R4: With `WITH_SAFETY`=1 the output cycles through 0xBD, 0xBB, 0xB7, 0xE7, 0xD7, 0xB7 and then repeats. 0xB7 means both streets are red.
- R5: Green rows hold for 10 ticks. Yellow rows and all-red rows hold for 5 ticks. A row with hold H lasts exactly H×`CLKS_PER_TICK` clock cycles.
- R6: The prescaler emits one tick every `CLKS_PER_TICK` clocks. It starts counting from zero after reset, so the first row lasts exactly H0×`CLKS_PER_TICK` cycles after reset is released.
- R7: After the last row the index wraps to row 0, and the index never leaves the range 0 to `NUM_ENTRIES`-1.
- R8: The lamp output is registered. It changes only on the edge where a row's hold runs out.
- R9: A reset applied in the middle of a row restarts the sequence at row 0 with that row's full hold.
- R10: On each street exactly one lamp is lit at all times, and the two greens are never lit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lamps_n | output | 8 | Active-low lamp word; bits 7 and 0 are spare and stay high |

## Verification
A wrong index or a corrupted hold count shows at `lamps_n` no later than the end of the row in progress. The output either switches to a word outside the expected order or switches on the wrong cycle. A prescaler that is off by one moves every phase boundary by a whole tick per hold count, so the very first transition after reset is already late or early. The bench compares every cycle against a behavioural model of both tables. It also measures phase lengths from reset and after a reset in the middle of a row.

// File: rtl/tl_pkg.sv
package tl_pkg;

  localparam int LAMP_W = 8;
  localparam int HOLD_W = 8;

  // Active-low lamp words: bit6 R1, bit5 Y1, bit4 G1, bit3 R2, bit2 Y2, bit1 G2
  localparam logic [LAMP_W-1:0] W_R1_G2  = 8'hBD;
  localparam logic [LAMP_W-1:0] W_R1_Y2  = 8'hBB;
  localparam logic [LAMP_W-1:0] W_G1_R2  = 8'hE7;
  localparam logic [LAMP_W-1:0] W_Y1_R2  = 8'hD7;
  localparam logic [LAMP_W-1:0] W_ALLRED = 8'hB7;

  localparam logic [HOLD_W-1:0] HOLD_GREEN  = 8'd10;
  localparam logic [HOLD_W-1:0] HOLD_YELLOW = 8'd5;
  localparam logic [HOLD_W-1:0] HOLD_CLEAR  = 8'd5;

  typedef struct packed {
    logic [LAMP_W-1:0] lamps_n;
    logic [HOLD_W-1:0] hold;
  } phase_t;

  // Table contents; the stepping logic never looks inside these rows.
  function automatic phase_t phase_row(input int idx, input bit with_safety);
    phase_t r;
    r = '{lamps_n: W_ALLRED, hold: HOLD_CLEAR};
    if (with_safety) begin
      case (idx)
        0: r = '{lamps_n: W_R1_G2,  hold: HOLD_GREEN};
        1: r = '{lamps_n: W_R1_Y2,  hold: HOLD_YELLOW};
        2: r = '{lamps_n: W_ALLRED, hold: HOLD_CLEAR};
        3: r = '{lamps_n: W_G1_R2,  hold: HOLD_GREEN};
        4: r = '{lamps_n: W_Y1_R2,  hold: HOLD_YELLOW};
        default: r = '{lamps_n: W_ALLRED, hold: HOLD_CLEAR};
      endcase
    end else begin
      case (idx)
        0: r = '{lamps_n: W_R1_G2,  hold: HOLD_GREEN};
        1: r = '{lamps_n: W_R1_Y2,  hold: HOLD_YELLOW};
        2: r = '{lamps_n: W_G1_R2,  hold: HOLD_GREEN};
        default: r = '{lamps_n: W_Y1_R2, hold: HOLD_YELLOW};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/tl_tick_div.sv
module tl_tick_div #(
  parameter int CLKS_PER_TICK = 50_000_000,
  localparam int CNT_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_TICK - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // R6: count never leaves the divider range
  assert_prescale_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R6: a tick is followed by a restart of the count from zero
  assert_prescale_restart_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/tl_phase_rom.sv
module tl_phase_rom import tl_pkg::*; #(
  parameter bit WITH_SAFETY = 1'b1,
  parameter int NUM_ENTRIES = WITH_SAFETY ? 6 : 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [IDX_W-1:0] addr,
  output phase_t           row
);

  phase_t rom [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_row
    assign rom[g] = phase_row(g, WITH_SAFETY);
  end

  assign row = rom[addr];

endmodule

// File: rtl/tl_step_ctrl.sv
module tl_step_ctrl import tl_pkg::*; #(
  parameter int NUM_ENTRIES = 6,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [HOLD_W-1:0] rd_hold,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              advance
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_nxt;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_load;

  assign idx_nxt   = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  assign rd_addr   = rst ? '0 : idx_nxt;
  assign advance   = tick && (hold_q <= HOLD_W'(1));
  assign hold_load = (rd_hold == '0) ? HOLD_W'(1) : rd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      hold_q <= hold_load;
    end else if (advance) begin
      idx_q  <= idx_nxt;
      hold_q <= hold_load;
    end else if (tick) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  // R7: index stays inside the table
  assert_index_range_R7: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);

  // R7: leaving the last row goes to row zero
  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && idx_q == LAST_IDX) |=> (idx_q == '0));

  // R8: index moves only on an expiring hold
  assert_index_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(idx_q));

  // R5: hold counter never reaches zero while running
  assert_hold_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    hold_q != '0);

endmodule

// File: rtl/traffic_seq.sv
module traffic_seq import tl_pkg::*; #(
  parameter int CLKS_PER_TICK = 50_000_000,
  parameter bit WITH_SAFETY   = 1'b1,
  parameter int NUM_ENTRIES   = WITH_SAFETY ? 6 : 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LAMP_W-1:0] lamps_n
);

  logic             tick;
  logic             advance;
  logic [IDX_W-1:0] rd_addr;
  phase_t           rd_row;
  logic [LAMP_W-1:0] lamps_q;

  tl_tick_div #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  tl_phase_rom #(.WITH_SAFETY(WITH_SAFETY), .NUM_ENTRIES(NUM_ENTRIES)) u_rom (
    .addr(rd_addr),
    .row (rd_row)
  );

  tl_step_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .rd_hold(rd_row.hold),
    .rd_addr(rd_addr),
    .advance(advance)
  );

  always_ff @(posedge clk) begin
    if (rst || advance) lamps_q <= rd_row.lamps_n;
  end

  assign lamps_n = lamps_q;

  localparam logic [LAMP_W-1:0] FIRST_WORD = phase_row(0, WITH_SAFETY).lamps_n;

  // R1: reset loads row zero's word
  assert_reset_word_R1: assert property (@(posedge clk)
    rst |=> (lamps_q == FIRST_WORD));

  // R2: spare bits stay high
  assert_spare_high_R2: assert property (@(posedge clk) disable iff (rst)
    lamps_q[7] && lamps_q[0]);

  // R10: one lamp lit per street, never two greens
  assert_one_lamp_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(~lamps_q[6:4]) == 1) && ($countones(~lamps_q[3:1]) == 1)
    && (lamps_q[4] || lamps_q[1]));

  // R8: output moves only on an expiring hold
  assert_stable_out_R8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(lamps_q));

endmodule

// File: tb/traffic_seq_test.sv
module traffic_seq_test;

  localparam int CPT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] lamps_e;
  logic [7:0] lamps_b;

  always #2 clk = ~clk; // 250 MHz

  traffic_seq #(.CLKS_PER_TICK(CPT), .WITH_SAFETY(1'b1)) uut (
    .clk(clk), .rst(rst), .lamps_n(lamps_e));

  traffic_seq #(.CLKS_PER_TICK(CPT), .WITH_SAFETY(1'b0)) uut_base (
    .clk(clk), .rst(rst), .lamps_n(lamps_b));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  // Independent expectations from the requirements
  int pat_e [6] = '{8'hBD, 8'hBB, 8'hB7, 8'hE7, 8'hD7, 8'hB7};
  int hld_e [6] = '{10, 5, 5, 10, 5, 5};
  int pat_b [4] = '{8'hBD, 8'hBB, 8'hE7, 8'hD7};
  int hld_b [4] = '{10, 5, 10, 5};

  int ie, re, ib, rb;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: remaining cycles per row
  always @(posedge clk) begin
    if (rst) begin
      ie = 0; re = hld_e[0] * CPT;
      ib = 0; rb = hld_b[0] * CPT;
      cmp_en <= 1'b1;
    end else begin
      re--;
      if (re == 0) begin ie = (ie + 1) % 6; re = hld_e[ie] * CPT; end
      rb--;
      if (rb == 0) begin ib = (ib + 1) % 4; rb = hld_b[ib] * CPT; end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(lamps_e == 8'(pat_e[ie]), "R4 R5 R7 R8 R9 safety sequence", lamps_e, pat_e[ie]);
      check(lamps_b == 8'(pat_b[ib]), "R3 R5 R7 R8 base sequence", lamps_b, pat_b[ib]);
      check(lamps_e[7] && lamps_e[0] && lamps_b[7] && lamps_b[0],
            "R2 spare bits high", {lamps_e, lamps_b}, 16'h8181);
      check(($countones(~lamps_e[6:4]) == 1) && ($countones(~lamps_e[3:1]) == 1)
            && (lamps_e[4] || lamps_e[1]), "R10 one lamp per street", lamps_e, 0);
    end
  end

  // Count edges until the safety-table output leaves the given word
  task automatic run_length(input logic [7:0] word, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (lamps_e == word && n < 1000);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(lamps_e == 8'hBD, "R1 reset word safety table", lamps_e, 8'hBD);
    check(lamps_b == 8'hBD, "R1 reset word base table", lamps_b, 8'hBD);
    rst = 1'b0;
    run_length(8'hBD, n);
    check(n == 10 * CPT, "R6 first phase length from reset", n, 10 * CPT);
    check(lamps_e == 8'hBB, "R4 second row word", lamps_e, 8'hBB);
    run_length(8'hBB, n);
    check(n == 5 * CPT, "R5 yellow length", n, 5 * CPT);
    run_length(8'hB7, n);
    check(n == 5 * CPT, "R5 all-red length", n, 5 * CPT);
    // Let the tables wrap twice
    repeat (2 * 40 * CPT) @(posedge clk);
    // Mid-row reset inside the street-1 green row
    while (lamps_e != 8'hE7) @(posedge clk);
    repeat (7) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(lamps_e == 8'hBD, "R9 restart at row zero", lamps_e, 8'hBD);
    run_length(8'hBD, n);
    check(n == 10 * CPT, "R9 full hold after mid-row reset", n, 10 * CPT);
    repeat (50 * CPT) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule